// File: doc/BRIEF.md
# Command-Stream Register Write Engine

The engine walks a region of a word-addressed command buffer and turns each command it finds into register write transactions on a memory-mapped write port. Software places 32-bit command words in the buffer, loads a small table that maps 24-bit base keys to physical base addresses, and then pulses `start` with a first word index and a word count. The engine reads one word at a time through a synchronous read port with one cycle of latency. It decodes the operation code in the top byte of each command's first word and consumes that command's header and payload words.

Four command families are handled. Sequential writes store a run of data words at consecutive addresses. Paired writes take an (offset, value) list. A base switch selects a new current base from the table. Lookup-table loads come in three variants, which push payload words into the data registers of a target table port. Every write address is the current base plus a 24-bit offset. Before it accepts a command, the engine checks the whole command against the words left in the region. When a run ends, the engine reports either normal completion or an error cause together with the buffer index of the command that failed.

Top module: `cmd_wr_engine`

## Requirements
- R1: After reset the engine is idle (`busy`, `done`, `err`, `wr_valid`, `buf_re` low, `err_code` 0), and the current base is marked invalid.
- R2: The operation code is bits 31:24 of a command's first word. Supported codes are 0x01 (table load, data at +8), 0x03 (sequential), 0x04 (paired), 0x08 (base switch), 0x0A (table load, data at +12) and 0x0B (wide table load). Any other code stops the run with `err_code` 5.
- R3: Sequential (0x03) takes its count from bits 15:0 of word 0 and its offset from bits 23:0 of word 1. The count data words that follow are written in order to base+offset, base+offset+4, and so on.
- R4: Paired (0x04) takes its count from bits 15:0. It is followed by count pairs, and each pair writes its value word to base + bits 23:0 of its offset word. Bits 31:24 of the offset word are ignored.
- R5: Base switch (0x08) looks up bits 23:0 in the table. Only valid entries take part, and among equal keys the lowest slot wins. On a hit, that entry's physical base becomes current and stays current across later runs. On a miss, the run stops with `err_code` 3 and the current base is left as it was.
- R6: A table load has a 3-word header. Word 0 bits 15:0 hold the byte length minus one, word 1 is ignored, and word 2 bits 23:0 hold the target offset (bits 31:24 ignored). Codes 0x01 and 0x0A make (length+1)/4 writes to base+target+8 and base+target+12 respectively, consuming that many payload words. If that number is zero, only the header is consumed.
- R7: The wide load (0x0B) makes (length+1)/8 iterations. Each iteration writes its first payload word to base+target+12 and then its second payload word to base+target+8.
- R8: A table load issued while no valid base is current stops the run with `err_code` 4.
- R9: A sequential or paired command with count 0 stops the run with `err_code` 1. Any command whose header plus payload exceeds the words left in the region stops the run with `err_code` 2. A rejected command issues no write.
- R10: Each write is offered with `wr_valid`, and its address and data are held stable until `wr_ready` is seen. At most one write completes per cycle, and no buffer read is made while a write is pending.
- R11: A run covers exactly `word_cnt` words from `start_idx` (0 words gives immediate completion). At the end of a run, exactly one of `done` and `err` is set and held until the next `start`. On error, `err_index` holds the index of the failing command's first word.
- R12: The configuration port writes one table slot per cycle (key 24 bits, physical base 32 bits, valid bit). After reset, every slot is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write one base table slot |
| cfg_slot | input | 3 | Slot index |
| cfg_key | input | 24 | Key stored in the slot |
| cfg_phys | input | 32 | Physical base stored in the slot |
| cfg_valid | input | 1 | Valid bit stored in the slot |
| start | input | 1 | Begin a run (accepted while idle) |
| start_idx | input | 8 | First buffer word index |
| word_cnt | input | 9 | Number of words in the run |
| buf_re | output | 1 | Buffer read enable |
| buf_addr | output | 8 | Buffer read index |
| buf_rdata | input | 32 | Read data, one cycle after `buf_re` |
| wr_valid | output | 1 | Write request |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | 32 | Write byte address |
| wr_data | output | 32 | Write data |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run completed without error |
| err | output | 1 | Run stopped on an error |
| err_code | output | 3 | 1 zero count, 2 overrun, 3 base miss, 4 no base, 5 bad code |
| err_index | output | 8 | First word index of the failing command |

## Verification
A scoreboard compares every accepted write against a list computed from the command words, while `wr_ready` follows a pseudo-random pattern so that stalls land on every kind of payload word. One long mixed stream chains base switches, sequential, paired and all three table-load variants. This stream separates the address rules from each other: +4 stepping, offset masking, the +8 and +12 targets, and the order of the high and low halves in the wide load. Short streams then trigger each error cause on its own. Among them are a failure after a good command, which shows that earlier writes still complete and that `err_index` points at the right word, and a zero-write table load, which shows that the header alone is consumed. A stray base lookup that first misses and is then followed by writes shows that the old base survives the miss.

// File: rtl/cwe_pkg.sv
package cwe_pkg;
    localparam int WORD_W = 32;
    localparam int OFS_W  = 24;
    localparam int NEED_W = 18;

    localparam logic [7:0] OP_LUT    = 8'h01;
    localparam logic [7:0] OP_SEQW   = 8'h03;
    localparam logic [7:0] OP_PAIRW  = 8'h04;
    localparam logic [7:0] OP_BASE   = 8'h08;
    localparam logic [7:0] OP_LUT32  = 8'h0A;
    localparam logic [7:0] OP_LUT64  = 8'h0B;

    localparam logic [WORD_W-1:0] LUT_LO_OFS = 32'd12;
    localparam logic [WORD_W-1:0] LUT_HI_OFS = 32'd8;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_COUNT   = 3'd1,
        ERR_OVERRUN = 3'd2,
        ERR_MISS    = 3'd3,
        ERR_NOBASE  = 3'd4,
        ERR_OPCODE  = 3'd5
    } err_e;

    typedef enum logic [2:0] {
        K_SEQ, K_PAIR, K_LUT8, K_LUT12, K_LUT64
    } kind_e;

    typedef enum logic [2:0] {
        PH_OP, PH_H1, PH_H2, PH_ROFF, PH_DATA
    } phase_e;

    typedef enum logic [1:0] {
        ST_IDLE, ST_FETCH, ST_GOT, ST_WRITE
    } state_e;

    typedef struct packed {
        logic [OFS_W-1:0]  key;
        logic [WORD_W-1:0] phys;
        logic              valid;
    } base_ent_t;

    typedef struct packed {
        logic              known;
        logic              is_base;
        logic              is_lut;
        kind_e             kind;
        logic              zero_cnt;
        logic [NEED_W-1:0] pay;
        logic [NEED_W-1:0] need;
    } dec_t;
endpackage

// File: rtl/cwe_decode.sv
module cwe_decode
    import cwe_pkg::*;
(
    input  logic [7:0]  op,
    input  logic [15:0] fld,
    output dec_t        dec
);
    logic [16:0]       len1;
    logic [3:0]        hdr;

    always_comb begin
        len1         = {1'b0, fld} + 17'd1;
        hdr          = 4'd1;
        dec          = '0;
        dec.kind     = K_SEQ;
        dec.known    = 1'b1;
        unique case (op)
            OP_SEQW: begin
                hdr          = 4'd2;
                dec.pay      = {2'b00, fld};
                dec.zero_cnt = (fld == 16'd0);
            end
            OP_PAIRW: begin
                dec.kind     = K_PAIR;
                dec.pay      = {1'b0, fld, 1'b0};
                dec.zero_cnt = (fld == 16'd0);
            end
            OP_BASE: begin
                dec.is_base  = 1'b1;
            end
            OP_LUT, OP_LUT32: begin
                hdr          = 4'd3;
                dec.is_lut   = 1'b1;
                dec.kind     = (op == OP_LUT) ? K_LUT8 : K_LUT12;
                dec.pay      = {3'b000, len1[16:2]};
            end
            OP_LUT64: begin
                hdr          = 4'd3;
                dec.is_lut   = 1'b1;
                dec.kind     = K_LUT64;
                dec.pay      = {3'b000, len1[16:3], 1'b0};
            end
            default: begin
                dec.known    = 1'b0;
            end
        endcase
        dec.need = dec.pay + NEED_W'(hdr);
    end
endmodule

// File: rtl/cwe_base_table.sv
module cwe_base_table
    import cwe_pkg::*;
#(
    parameter  int ENTRIES = 8,
    localparam int SLOT_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  base_ent_t         cfg_ent,
    input  logic [OFS_W-1:0]  look_key,
    output logic              hit,
    output logic [WORD_W-1:0] hit_phys
);
    base_ent_t            tbl [ENTRIES];
    logic [ENTRIES-1:0]   match;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
        end else if (cfg_we) begin
            tbl[cfg_slot] <= cfg_ent;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = tbl[g].valid && (tbl[g].key == look_key);
    end

    always_comb begin
        hit_phys = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) hit_phys = tbl[i].phys;
        end
        hit = |match;
    end
endmodule

// File: rtl/cwe_sequencer.sv
module cwe_sequencer
    import cwe_pkg::*;
#(
    parameter  int IDX_W = 8,
    localparam int PTR_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [IDX_W-1:0]  start_idx,
    input  logic [PTR_W-1:0]  word_cnt,
    input  logic [WORD_W-1:0] rdata,
    input  dec_t              dec,
    input  logic              lk_hit,
    input  logic [WORD_W-1:0] lk_phys,
    output logic              buf_re,
    output logic [IDX_W-1:0]  buf_addr,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [WORD_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [2:0]        err_code,
    output logic [IDX_W-1:0]  err_index
);
    state_e            state;
    phase_e            phase;
    kind_e             kind;
    logic [PTR_W-1:0]  ptr, endp;
    logic [NEED_W-1:0] cnt;
    logic [WORD_W-1:0] cur_addr, data_q, base_phys, base_plus;
    logic              base_ok, hi_sel, at_end;
    logic [NEED_W-1:0] rem;

    assign at_end    = (phase == PH_OP) && (ptr == endp);
    assign rem       = NEED_W'(endp - ptr);
    assign base_plus = base_phys + {8'h00, rdata[OFS_W-1:0]};

    assign buf_re    = (state == ST_FETCH) && !at_end;
    assign buf_addr  = ptr[IDX_W-1:0];
    assign wr_valid  = (state == ST_WRITE);
    assign wr_addr   = cur_addr;
    assign wr_data   = data_q;
    assign busy      = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            phase     <= PH_OP;
            kind      <= K_SEQ;
            ptr       <= '0;
            endp      <= '0;
            cnt       <= '0;
            cur_addr  <= '0;
            data_q    <= '0;
            base_phys <= '0;
            base_ok   <= 1'b0;
            hi_sel    <= 1'b0;
            done      <= 1'b0;
            err       <= 1'b0;
            err_code  <= ERR_NONE;
            err_index <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    ptr      <= PTR_W'(start_idx);
                    endp     <= PTR_W'(start_idx) + word_cnt;
                    done     <= 1'b0;
                    err      <= 1'b0;
                    err_code <= ERR_NONE;
                    phase    <= PH_OP;
                    state    <= ST_FETCH;
                end
                ST_FETCH: begin
                    if (at_end) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        state <= ST_GOT;
                    end
                end
                ST_GOT: begin
                    state <= ST_FETCH;
                    ptr   <= ptr + 1'b1;
                    unique case (phase)
                        PH_OP: begin
                            if (!dec.known || (dec.is_lut && !base_ok) || dec.zero_cnt
                                || (dec.need > rem) || (dec.is_base && !lk_hit)) begin
                                err       <= 1'b1;
                                err_index <= ptr[IDX_W-1:0];
                                state     <= ST_IDLE;
                                if (!dec.known)                 err_code <= ERR_OPCODE;
                                else if (dec.is_lut && !base_ok) err_code <= ERR_NOBASE;
                                else if (dec.zero_cnt)          err_code <= ERR_COUNT;
                                else if (dec.need > rem)        err_code <= ERR_OVERRUN;
                                else                            err_code <= ERR_MISS;
                            end else if (dec.is_base) begin
                                base_phys <= lk_phys;
                                base_ok   <= 1'b1;
                            end else begin
                                kind  <= dec.kind;
                                cnt   <= dec.pay;
                                phase <= (dec.kind == K_PAIR) ? PH_ROFF : PH_H1;
                            end
                        end
                        PH_H1: begin
                            if (kind == K_SEQ) begin
                                cur_addr <= base_plus;
                                phase    <= PH_DATA;
                            end else begin
                                phase    <= PH_H2;
                            end
                        end
                        PH_H2: begin
                            cur_addr <= base_plus + ((kind == K_LUT8) ? LUT_HI_OFS : LUT_LO_OFS);
                            hi_sel   <= 1'b0;
                            phase    <= (cnt == '0) ? PH_OP : PH_DATA;
                        end
                        PH_ROFF: begin
                            cur_addr <= base_plus;
                            cnt      <= cnt - 1'b1;
                            phase    <= PH_DATA;
                        end
                        PH_DATA: begin
                            data_q <= rdata;
                            cnt    <= cnt - 1'b1;
                            state  <= ST_WRITE;
                        end
                        default: phase <= PH_OP;
                    endcase
                end
                ST_WRITE: if (wr_ready) begin
                    if (kind == K_SEQ) begin
                        cur_addr <= cur_addr + 32'd4;
                    end else if (kind == K_LUT64) begin
                        cur_addr <= hi_sel ? cur_addr + 32'd4 : cur_addr - 32'd4;
                        hi_sel   <= ~hi_sel;
                    end
                    if (cnt == '0)         phase <= PH_OP;
                    else if (kind == K_PAIR) phase <= PH_ROFF;
                    else                   phase <= PH_DATA;
                    state <= ST_FETCH;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cmd_wr_engine.sv
module cmd_wr_engine
    import cwe_pkg::*;
#(
    parameter  int IDX_W   = 8,
    parameter  int ENTRIES = 8,
    localparam int SLOT_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic [23:0]       cfg_key,
    input  logic [31:0]       cfg_phys,
    input  logic              cfg_valid,
    input  logic              start,
    input  logic [IDX_W-1:0]  start_idx,
    input  logic [IDX_W:0]    word_cnt,
    output logic              buf_re,
    output logic [IDX_W-1:0]  buf_addr,
    input  logic [31:0]       buf_rdata,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [31:0]       wr_addr,
    output logic [31:0]       wr_data,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [2:0]        err_code,
    output logic [IDX_W-1:0]  err_index
);
    dec_t              dec;
    base_ent_t         cfg_ent;
    logic              lk_hit;
    logic [WORD_W-1:0] lk_phys;

    assign cfg_ent = '{key: cfg_key, phys: cfg_phys, valid: cfg_valid};

    cwe_decode u_decode (
        .op  (buf_rdata[31:24]),
        .fld (buf_rdata[15:0]),
        .dec (dec)
    );

    cwe_base_table #(.ENTRIES(ENTRIES)) u_table (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_slot (cfg_slot),
        .cfg_ent  (cfg_ent),
        .look_key (buf_rdata[OFS_W-1:0]),
        .hit      (lk_hit),
        .hit_phys (lk_phys)
    );

    cwe_sequencer #(.IDX_W(IDX_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .start_idx (start_idx),
        .word_cnt  (word_cnt),
        .rdata     (buf_rdata),
        .dec       (dec),
        .lk_hit    (lk_hit),
        .lk_phys   (lk_phys),
        .buf_re    (buf_re),
        .buf_addr  (buf_addr),
        .wr_valid  (wr_valid),
        .wr_ready  (wr_ready),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .err_code  (err_code),
        .err_index (err_index)
    );
endmodule

// File: rtl/cwe_checker.sv
module cwe_checker (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic        err,
    input logic [2:0]  err_code,
    input logic        wr_valid,
    input logic        wr_ready,
    input logic [31:0] wr_addr,
    input logic [31:0] wr_data,
    input logic        buf_re
);
    AST_WRITE_HELD: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R10

    AST_NO_READ_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> !buf_re); // R10

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!wr_valid && !buf_re)); // R11

    AST_STATUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(done && err)); // R11

    AST_RUN_ENDS_REPORTED: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done || err)); // R11

    AST_ERR_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
        err |-> (err_code >= 3'd1 && err_code <= 3'd5)); // R9
endmodule

bind cmd_wr_engine cwe_checker u_cwe_checker (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .err_code (err_code),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .buf_re   (buf_re)
);

// File: tb/cmd_wr_engine_test.sv
`timescale 1ns/1ps
module cmd_wr_engine_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_slot = '0;
    logic [23:0] cfg_key = '0;
    logic [31:0] cfg_phys = '0;
    logic        cfg_valid = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  start_idx = '0;
    logic [8:0]  word_cnt = '0;
    logic        buf_re;
    logic [7:0]  buf_addr;
    logic [31:0] buf_rdata = '0;
    logic        wr_valid;
    logic        wr_ready = 1'b0;
    logic [31:0] wr_addr, wr_data;
    logic        busy, done, err;
    logic [2:0]  err_code;
    logic [7:0]  err_index;

    int checks = 0;
    int errors = 0;
    logic [31:0] mem [256];
    logic [63:0] exp_q [$];
    string       tag_q [$];
    logic [7:0]  lfsr = 8'hA5;

    always #2 clk = ~clk;

    cmd_wr_engine uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_key(cfg_key),
        .cfg_phys(cfg_phys), .cfg_valid(cfg_valid), .start(start), .start_idx(start_idx),
        .word_cnt(word_cnt), .buf_re(buf_re), .buf_addr(buf_addr), .buf_rdata(buf_rdata),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .done(done), .err(err), .err_code(err_code), .err_index(err_index)
    );

    always @(posedge clk) if (buf_re) buf_rdata <= mem[buf_addr];

    always @(posedge clk) begin
        #1;
        lfsr     <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        wr_ready <= lfsr[0] | lfsr[2];
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && wr_valid && wr_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected write", {wr_addr, wr_data}, 64'h0);
            end else begin
                logic [63:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({wr_addr, wr_data} == e, t, {wr_addr, wr_data}, e);
            end
        end
    end

    task automatic expect_wr(input logic [31:0] a, input logic [31:0] d, input string t);
        exp_q.push_back({a, d});
        tag_q.push_back(t);
    endtask

    task automatic cfg(input int slot, input logic [23:0] k, input logic [31:0] p, input bit v);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_slot = 3'(slot); cfg_key = k; cfg_phys = p; cfg_valid = v;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic run(input int sidx, input int cnt, input bit exp_err,
                       input int exp_code, input int exp_idx, input string req);
        int wd;
        @(posedge clk); #1;
        start = 1'b1; start_idx = 8'(sidx); word_cnt = 9'(cnt);
        @(posedge clk); #1;
        start = 1'b0;
        wd = 0;
        @(negedge clk);
        while (!(done || err) && wd < 20000) begin
            @(negedge clk);
            wd++;
        end
        if (wd >= 20000) check(1'b0, {req, " watchdog"}, 64'(wd), 64'h0);
        check(err == exp_err && done == !exp_err, {req, " R11 status"}, {err, done}, {exp_err, !exp_err});
        if (exp_err) begin
            check(err_code == 3'(exp_code), {req, " code"}, 64'(err_code), 64'(exp_code));
            check(err_index == 8'(exp_idx), {req, " R11 index"}, 64'(err_index), 64'(exp_idx));
        end
        check(exp_q.size() == 0, {req, " R9 pending writes"}, 64'(exp_q.size()), 64'h0);
        exp_q.delete();
        tag_q.delete();
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!busy && !done && !err && !wr_valid && !buf_re && err_code == 3'd0,
              "R1 reset", {busy, done, err, wr_valid, buf_re, err_code}, 64'h0);

        // R12 table load: slot 2 and 6 share a key, slot 7 invalid
        cfg(2, 24'h000100, 32'h4000_0000, 1'b1);
        cfg(5, 24'h000200, 32'h5000_0000, 1'b1);
        cfg(6, 24'h000100, 32'h6000_0000, 1'b1);
        cfg(7, 24'h000300, 32'h7000_0000, 1'b0);

        // R8 table load with no base after reset
        mem[0] = 32'h0100_0003; mem[1] = 0; mem[2] = 32'h10; mem[3] = 32'h1;
        run(0, 4, 1, 4, 0, "R8 no base");

        // Mixed stream R2 R3 R4 R5 R6 R7
        mem[10] = 32'h0800_0100;
        mem[11] = 32'h0300_0003; mem[12] = 32'h0000_0020;
        mem[13] = 32'h1111_1111; mem[14] = 32'h2222_2222; mem[15] = 32'h3333_3333;
        mem[16] = 32'h0400_0002; mem[17] = 32'h0000_0044; mem[18] = 32'hAAAA_0001;
        mem[19] = 32'hAB00_0050; mem[20] = 32'hBBBB_0002;
        mem[21] = 32'h0800_0200;
        mem[22] = 32'h0100_0007; mem[23] = 32'hDEAD_0000; mem[24] = 32'h0700_0300;
        mem[25] = 32'hC000_0001; mem[26] = 32'hC000_0002;
        mem[27] = 32'h0A00_0003; mem[28] = 32'h0; mem[29] = 32'h0000_0400; mem[30] = 32'hC100_0001;
        mem[31] = 32'h0B00_000F; mem[32] = 32'h0; mem[33] = 32'h0000_0500;
        mem[34] = 32'hD000_0000; mem[35] = 32'hD000_0001; mem[36] = 32'hD000_0002; mem[37] = 32'hD000_0003;
        expect_wr(32'h4000_0020, 32'h1111_1111, "R3 seq w0 (R5 lowest slot)");
        expect_wr(32'h4000_0024, 32'h2222_2222, "R3 seq w1");
        expect_wr(32'h4000_0028, 32'h3333_3333, "R3 seq w2");
        expect_wr(32'h4000_0044, 32'hAAAA_0001, "R4 pair 0");
        expect_wr(32'h4000_0050, 32'hBBBB_0002, "R4 pair 1 masked offset");
        expect_wr(32'h5000_0308, 32'hC000_0001, "R6 lut +8 w0");
        expect_wr(32'h5000_0308, 32'hC000_0002, "R6 lut +8 w1");
        expect_wr(32'h5000_040C, 32'hC100_0001, "R6 lut +12");
        expect_wr(32'h5000_050C, 32'hD000_0000, "R7 wide it0 first");
        expect_wr(32'h5000_0508, 32'hD000_0001, "R7 wide it0 second");
        expect_wr(32'h5000_050C, 32'hD000_0002, "R7 wide it1 first");
        expect_wr(32'h5000_0508, 32'hD000_0003, "R7 wide it1 second");
        run(10, 28, 0, 0, 0, "R2 mixed stream");

        // R5 miss on invalid slot, base kept
        mem[40] = 32'h0800_0300;
        run(40, 1, 1, 3, 40, "R5 base miss");
        mem[41] = 32'h0400_0001; mem[42] = 32'h0000_0060; mem[43] = 32'h1234_5678;
        expect_wr(32'h5000_0060, 32'h1234_5678, "R5 base kept after miss");
        run(41, 3, 0, 0, 0, "R5 after miss");

        // R9 zero count
        mem[50] = 32'h0300_0000; mem[51] = 32'h4; mem[52] = 32'h5; mem[53] = 32'h6;
        run(50, 4, 1, 1, 50, "R9 zero count");

        // R9 overrun after a good command
        mem[60] = 32'h0300_0001; mem[61] = 32'h10; mem[62] = 32'h99;
        mem[63] = 32'h0400_0005; mem[64] = 32'h1; mem[65] = 32'h2; mem[66] = 32'h3;
        expect_wr(32'h5000_0010, 32'h99, "R3 before overrun");
        run(60, 7, 1, 2, 63, "R9 overrun");

        // R9 header itself past the end
        mem[100] = 32'h0300_0001;
        run(100, 1, 1, 2, 100, "R9 header overrun");

        // R2 unsupported code after good command
        mem[70] = 32'h0400_0001; mem[71] = 32'h70; mem[72] = 32'h77;
        mem[73] = 32'h0500_0000; mem[74] = 32'h0;
        expect_wr(32'h5000_0070, 32'h77, "R4 before bad code");
        run(70, 5, 1, 5, 73, "R2 bad code");

        // R11 empty run
        run(80, 0, 0, 0, 0, "R11 empty run");

        // R6 zero-write table load consumes header only
        mem[90] = 32'h0100_0002; mem[91] = 32'h0; mem[92] = 32'h0000_0100;
        mem[93] = 32'h0400_0001; mem[94] = 32'h80; mem[95] = 32'h88;
        expect_wr(32'h5000_0080, 32'h88, "R6 zero-write load then pair");
        run(90, 6, 0, 0, 0, "R6 zero-write load");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule